// File: doc/BRIEF.md
# AES Byte Substitution with Split Inverse Table

This block performs the AES byte substitution and its inverse on one byte. Rather than storing the full substitution table, it keeps only the multiplicative inverse over GF(2^8) as constant data. The affine mapping is computed in XOR logic around that lookup.

The inverse data is divided by Shannon expansion into four sub-tables of 64 bytes each. The lower six bits of the lookup address index every sub-table in parallel. The upper two bits steer a 4:1 byte multiplexer that picks one sub-table's entry.

In forward mode the byte goes through the inverse table and then the forward affine map. In inverse mode it goes through the inverse affine map and then the same inverse table. A parameter selects either a purely combinational result or a result held in one 8-bit register. Nothing wider than the result byte is ever registered.

Top module: `aes_sbox_split`

## Requirements
- R1: With `inv_sel`=0, `dout` equals A(inv(`din`)). Here inv is the field inverse modulo x^8+x^4+x^3+x+1 (0x11B), and A(b) = b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 0x63, with rotl an 8-bit left rotation.
- R2: With `inv_sel`=1, `dout` equals inv(B(`din`)), where B(b) = rotl(b,1) ^ rotl(b,3) ^ rotl(b,6) ^ 0x05.
- R3: The inverse of 0x00 is taken as 0x00. So the forward result of 0x00 is 0x63, and the inverse result of 0x63 is 0x00.
- R4: The table lookup selects the group given by bits [7:6] of its address and the entry given by bits [5:0]. In forward mode, undoing A on `dout` must yield the field inverse of `din` for every input in each of the four groups.
- R5: The inverse mode undoes the forward mode: applying inverse mode to the forward result of x gives x back, for all 256 values of x.
- R6: The forward result never equals `din` and never equals the bitwise complement of `din`.
- R7: With REG_OUT=1, `dout` presents the result for the inputs sampled at a rising edge of `clk`, one cycle after they were applied.
- R8: With REG_OUT=1, a low `rst_n` sampled at a rising edge sets `dout` to 0x00 (synchronous reset).
- R9: With REG_OUT=0, `dout` follows `din` and `inv_sel` with no clock edge and is not affected by `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| inv_sel | input | 1 | 0 selects forward substitution, 1 selects inverse substitution |
| din | input | 8 | Byte to substitute |
| dout | output | 8 | Substituted byte |

## Verification
The bench builds two copies of the block: `uut` with REG_OUT=1 and a second copy with REG_OUT=0. Both are fed the same stimulus. This covers the registered latency and synchronous reset alongside the combinational path. Because the input is one byte, every value is swept in both directions against field arithmetic done in the bench. That sweep covers all four sub-tables, the zero-inverse special case, the round trip and the absence of fixed points.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

    localparam int BYTE_W   = 8;
    localparam int N_GROUPS = 4;
    localparam int SEL_W    = $clog2(N_GROUPS);
    localparam int IDX_W    = BYTE_W - SEL_W;
    localparam int GRP_LEN  = 1 << IDX_W;

    localparam logic [BYTE_W-1:0] RED_POLY  = 8'h1B;
    localparam logic [BYTE_W-1:0] FWD_CONST = 8'h63;
    localparam logic [BYTE_W-1:0] INV_CONST = 8'h05;

    typedef enum logic {DIR_FWD = 1'b0, DIR_INV = 1'b1} dir_e;

    function automatic logic [BYTE_W-1:0] rotl(input logic [BYTE_W-1:0] b, input int n);
        logic [2*BYTE_W-1:0] wide;
        wide = {b, b} << n;
        return wide[2*BYTE_W-1:BYTE_W];
    endfunction

    function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                                 input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] acc;
        logic [BYTE_W-1:0] x;
        acc = '0;
        x   = a;
        for (int k = 0; k < BYTE_W; k++) begin
            if (b[k]) acc = acc ^ x;
            x = x[BYTE_W-1] ? ((x << 1) ^ RED_POLY) : (x << 1);
        end
        return acc;
    endfunction

    // a^254 is the inverse for nonzero a and yields 0 for a = 0
    function automatic logic [BYTE_W-1:0] gf_inv(input logic [BYTE_W-1:0] a);
        logic [BYTE_W-1:0] r;
        logic [BYTE_W-1:0] sq;
        r  = 8'h01;
        sq = a;
        for (int k = 0; k < BYTE_W; k++) begin
            if (k != 0) r = gf_mul(r, sq);
            sq = gf_mul(sq, sq);
        end
        return r;
    endfunction

endpackage

// File: rtl/sbox_affine.sv
module sbox_affine
    import sbox_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  logic [BYTE_W-1:0] a_in,
    output logic [BYTE_W-1:0] a_out
);

    generate
        if (INVERSE) begin : g_inv
            assign a_out = rotl(a_in, 1) ^ rotl(a_in, 3) ^ rotl(a_in, 6) ^ INV_CONST;
        end else begin : g_fwd
            assign a_out = a_in ^ rotl(a_in, 1) ^ rotl(a_in, 2)
                         ^ rotl(a_in, 3) ^ rotl(a_in, 4) ^ FWD_CONST;
        end
    endgenerate

endmodule

// File: rtl/sbox_inv_group.sv
module sbox_inv_group
    import sbox_pkg::*;
#(
    parameter int GRP = 0
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [BYTE_W-1:0] data
);

    localparam int BASE = GRP * GRP_LEN;

    logic [BYTE_W-1:0] rom [GRP_LEN];

    for (genvar i = 0; i < GRP_LEN; i++) begin : g_ent
        assign rom[i] = gf_inv(BYTE_W'(BASE + i));
    end

    assign data = rom[idx];

endmodule

// File: rtl/sbox_inv_table.sv
module sbox_inv_table
    import sbox_pkg::*;
(
    input  logic [BYTE_W-1:0] addr,
    output logic [BYTE_W-1:0] inv
);

    logic [BYTE_W-1:0] grp_out [N_GROUPS];
    logic [SEL_W-1:0]  grp_sel;

    assign grp_sel = addr[BYTE_W-1 -: SEL_W];

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        sbox_inv_group #(.GRP(g)) u_grp (
            .idx  (addr[IDX_W-1:0]),
            .data (grp_out[g])
        );
    end

    always_comb begin
        inv = '0;
        for (int g = 0; g < N_GROUPS; g++) begin
            if (grp_sel == SEL_W'(g)) inv = grp_out[g];
        end
    end

endmodule

// File: rtl/aes_sbox_split.sv
module aes_sbox_split
    import sbox_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_sel,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);

    typedef struct packed {
        logic [BYTE_W-1:0] res;
    } out_s;

    dir_e              dir;
    logic [BYTE_W-1:0] pre_aff;
    logic [BYTE_W-1:0] tbl_addr;
    logic [BYTE_W-1:0] tbl_inv;
    logic [BYTE_W-1:0] post_aff;
    logic [BYTE_W-1:0] result;

    assign dir = dir_e'(inv_sel);

    sbox_affine #(.INVERSE(1'b1)) u_aff_in (
        .a_in  (din),
        .a_out (pre_aff)
    );

    assign tbl_addr = (dir == DIR_INV) ? pre_aff : din;

    sbox_inv_table u_table (
        .addr (tbl_addr),
        .inv  (tbl_inv)
    );

    sbox_affine #(.INVERSE(1'b0)) u_aff_out (
        .a_in  (tbl_inv),
        .a_out (post_aff)
    );

    assign result = (dir == DIR_INV) ? tbl_inv : post_aff;

    generate
        if (REG_OUT) begin : g_reg
            out_s st_d, st_q;
            logic seen_d, seen_q;

            always_comb begin
                st_d.res = rst_n ? result : '0;
                seen_d   = rst_n;
            end

            always_ff @(posedge clk) begin
                st_q   <= st_d;
                seen_q <= seen_d;
            end

            assign dout = st_q.res;

            assert_reset_clears_R8: assert property (@(posedge clk)
                !rst_n |=> dout == '0);

            assert_zero_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (seen_q && $past(din) == '0 && !$past(inv_sel)) |-> dout == FWD_CONST);

            assert_zero_inv_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (seen_q && $past(din) == FWD_CONST && $past(inv_sel)) |-> dout == '0);

            assert_no_fixed_point_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (seen_q && !$past(inv_sel)) |-> (dout != $past(din) && dout != ~$past(din)));
        end else begin : g_comb
            assign dout = result;

            assert_zero_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (din == '0 && !inv_sel) |-> dout == FWD_CONST);

            assert_zero_inv_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (din == FWD_CONST && inv_sel) |-> dout == '0);

            assert_no_fixed_point_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !inv_sel |-> (dout != din && dout != ~din));

            assert_inv_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
                inv_sel |-> dout == tbl_inv);
        end
    endgenerate

endmodule

// File: tb/aes_sbox_split_test.sv
module aes_sbox_split_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       inv_sel = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout_r;
    logic [7:0] dout_c;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] inv_t [256];
    logic [7:0] fwd_t [256];
    logic [7:0] bwd_t [256];

    always #2.5 clk = ~clk;

    aes_sbox_split #(.REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .inv_sel(inv_sel), .din(din), .dout(dout_r));

    aes_sbox_split #(.REG_OUT(1'b0)) uut_c (
        .clk(clk), .rst_n(rst_n), .inv_sel(inv_sel), .din(din), .dout(dout_c));

    function automatic logic [7:0] rl(input logic [7:0] b, input int n);
        return (b << n) | (b >> (8 - n));
    endfunction

    function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc = 8'h00;
        logic [7:0] x = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) acc ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
        end
        return acc;
    endfunction

    function automatic logic [7:0] aff_f(input logic [7:0] b);
        return b ^ rl(b, 1) ^ rl(b, 2) ^ rl(b, 3) ^ rl(b, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] aff_b(input logic [7:0] b);
        return rl(b, 1) ^ rl(b, 3) ^ rl(b, 6) ^ 8'h05;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp,
                         input logic [7:0] stim);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s din=%02h actual=%02h expected=%02h", req, stim, act, exp);
        end
    endtask

    initial begin
        for (int a = 0; a < 256; a++) begin
            inv_t[a] = 8'h00;
            for (int b = 1; b < 256; b++)
                if (a != 0 && mul(8'(a), 8'(b)) == 8'h01) inv_t[a] = 8'(b);
        end
        for (int a = 0; a < 256; a++) begin
            fwd_t[a] = aff_f(inv_t[a]);
            bwd_t[a] = inv_t[aff_b(8'(a))];
        end

        // reset: registered output held at zero, combinational copy unaffected
        @(negedge clk); din = 8'h00; inv_sel = 1'b0;
        @(posedge clk); #1;
        check("R8", dout_r, 8'h00, din);
        check("R9", dout_c, 8'h63, din);
        @(posedge clk); #1;
        check("R8", dout_r, 8'h00, din);
        @(negedge clk); rst_n = 1'b1;

        for (int m = 0; m < 2; m++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] e;
                @(negedge clk);
                inv_sel = m[0];
                din     = 8'(v);
                e = m[0] ? bwd_t[v] : fwd_t[v];
                #1;
                check(m[0] ? "R2 R9" : "R1 R9", dout_c, e, din);
                @(posedge clk); #1;
                check(m[0] ? "R2 R7" : "R1 R7", dout_r, e, din);
                if (m == 0) begin
                    // R4: undoing the affine step yields the inverse from group din[7:6]
                    check("R4", mul(aff_b(dout_r), din), (v == 0) ? 8'h00 : 8'h01, din);
                    check("R6", 8'((dout_r == din) || (dout_r == ~din)), 8'h00, din);
                    check("R5", bwd_t[dout_r], din, din);
                end
            end
        end

        // R5: feed forward result back through the block in inverse mode
        for (int v = 0; v < 256; v += 37) begin
            logic [7:0] mid;
            @(negedge clk); inv_sel = 1'b0; din = 8'(v); #1;
            mid = dout_c;
            inv_sel = 1'b1; din = mid; #1;
            check("R5", dout_c, 8'(v), mid);
        end

        // R3 corner values
        @(negedge clk); inv_sel = 1'b0; din = 8'h00; #1;
        check("R3", dout_c, 8'h63, din);
        @(negedge clk); inv_sel = 1'b1; din = 8'h63; #1;
        check("R3", dout_c, 8'h00, din);
        @(posedge clk); #1;
        check("R3", dout_r, 8'h00, din);

        // R7: output holds the old result until the next edge
        @(negedge clk); inv_sel = 1'b0; din = 8'h53; #1;
        check("R7", dout_r, 8'h00, din);
        @(posedge clk); #1;
        check("R7", dout_r, 8'hED, din);

        // R8 again mid-run
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R8", dout_r, 8'h00, din);
        check("R9", dout_c, 8'hED, din);
        @(negedge clk); rst_n = 1'b1;

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule